// File: doc/BRIEF.md
# Width-Scaled Sign Extension Unit

This unit sign-extends a low field of a register-width operand to the full register width. It has three operations: byte, half and word. In the default scaled interpretation, each operation's field is a fixed fraction of the register width rather than a fixed bit count. Byte takes one eighth of the width, half takes a quarter and word takes a half. A narrow datapath therefore still uses all three operations: at 8 bits they extend 1, 2 and 4 bits, at 16 bits 2, 4 and 8, at 32 bits 4, 8 and 16, and at 64 bits 8, 16 and 32.

A per-request legacy input selects the fixed interpretation instead, where the three operations mean 8, 16 and 32 bits. A field as wide as the register or wider then leaves the operand untouched, which amounts to a truncation to the register width. Operation code 3 is reserved: the operand passes through unchanged and an illegal flag is raised. The operation, the mode and the operand are sampled together on a valid strobe, and the result is registered.

Top module: `sx_scaled_ext`

## Requirements
- R1: With legacy low and operation code 0 (byte), the result keeps the low XLEN/8 operand bits, and every higher bit equals operand bit XLEN/8-1.
- R2: With legacy low and operation code 1 (half), the result keeps the low XLEN/4 operand bits, and every higher bit equals operand bit XLEN/4-1.
- R3: With legacy low and operation code 2 (word), the result keeps the low XLEN/2 operand bits, and every higher bit equals operand bit XLEN/2-1.
- R4: The sign bit is the most significant bit of the selected field. A negative field fills all upper result bits with ones and a non-negative field fills them with zeros.
- R5: With legacy high, codes 0, 1 and 2 select fields of 8, 16 and 32 bits. A field narrower than XLEN is sign-extended as in R4.
- R6: With legacy high, a fixed field of XLEN bits or more gives a result equal to the operand.
- R7: Operation code 3 gives a result equal to the operand with out_illegal high. Codes 0 to 2 give out_illegal low.
- R8: out_valid is high in the cycle after each cycle in which in_valid was high, and low otherwise. The result and illegal flag belong to that request.
- R9: While in_valid is low, out_result and out_illegal keep their previous values, whatever the other inputs do.
- R10: While reset is applied, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe; samples operand, operation and mode |
| in_op | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| in_legacy | input | 1 | 1 selects fixed 8/16/32-bit fields, 0 the scaled fields |
| in_operand | input | XLEN | Source operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | XLEN | Extended result |
| out_illegal | output | 1 | Reserved operation code was requested |

## Verification
Every result of this block, including the result value, the illegal flag and the valid strobe, is due exactly one clock edge after the edge that sampled in_valid. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It reads the outputs at that same falling edge, half a period after the capturing rising edge. The hold test leaves the strobe low for a further cycle while the other inputs change, then reads the outputs again one falling edge later. Reset checks wait for the two-stage internal release before the first request.

// File: rtl/sx_pkg.sv
package sx_pkg;
  typedef enum logic [1:0] {
    SX_OP_BYTE = 2'd0,
    SX_OP_HALF = 2'd1,
    SX_OP_WORD = 2'd2,
    SX_OP_RSVD = 2'd3
  } sx_op_e;

  // fixed field widths used by the legacy interpretation
  localparam int unsigned SX_FIX_BYTE = 8;
  localparam int unsigned SX_FIX_HALF = 16;
  localparam int unsigned SX_FIX_WORD = 32;
endpackage

// File: rtl/sx_sign_pos.sv
module sx_sign_pos #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned PW = $clog2(XLEN)
) (
  input  sx_pkg::sx_op_e op,
  input  logic           legacy,
  output logic [PW-1:0]  sign_pos,
  output logic           illegal
);
  import sx_pkg::*;

  localparam int unsigned TOP = XLEN - 1;
  // scaled field MSB positions
  localparam int unsigned SC_B = XLEN / 8 - 1;
  localparam int unsigned SC_H = XLEN / 4 - 1;
  localparam int unsigned SC_W = XLEN / 2 - 1;
  // legacy field MSB positions, clamped to the top bit (no-op or truncation)
  localparam int unsigned LG_B = (SX_FIX_BYTE < XLEN) ? SX_FIX_BYTE - 1 : TOP;
  localparam int unsigned LG_H = (SX_FIX_HALF < XLEN) ? SX_FIX_HALF - 1 : TOP;
  localparam int unsigned LG_W = (SX_FIX_WORD < XLEN) ? SX_FIX_WORD - 1 : TOP;

  always_comb begin
    illegal  = 1'b0;
    sign_pos = PW'(TOP);
    unique case (op)
      SX_OP_BYTE: sign_pos = legacy ? PW'(LG_B) : PW'(SC_B);
      SX_OP_HALF: sign_pos = legacy ? PW'(LG_H) : PW'(SC_H);
      SX_OP_WORD: sign_pos = legacy ? PW'(LG_W) : PW'(SC_W);
      SX_OP_RSVD: begin
        sign_pos = PW'(TOP);
        illegal  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sx_extend.sv
module sx_extend #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned PW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] operand,
  input  logic [PW-1:0]   sign_pos,
  output logic [XLEN-1:0] result
);
  logic sign_bit;
  assign sign_bit = operand[sign_pos];

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign result[i] = (PW'(i) <= sign_pos) ? operand[i] : sign_bit;
  end
endmodule

// File: rtl/sx_scaled_ext.sv
module sx_scaled_ext #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic            in_legacy,
  input  logic [XLEN-1:0] in_operand,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  import sx_pkg::*;

  localparam int unsigned PW = $clog2(XLEN);
  localparam int unsigned FB = XLEN / 8;
  localparam int unsigned FH = XLEN / 4;
  localparam int unsigned FW = XLEN / 2;

  initial begin
    if (!(XLEN == 8 || XLEN == 16 || XLEN == 32 || XLEN == 64))
      $error("sx_scaled_ext: XLEN must be 8, 16, 32 or 64");
  end

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ok = rst_q[1];

  logic [PW-1:0]   sign_pos;
  logic            illegal_c;
  logic [XLEN-1:0] ext_c;

  sx_sign_pos #(.XLEN(XLEN)) u_pos (
    .op       (sx_op_e'(in_op)),
    .legacy   (in_legacy),
    .sign_pos (sign_pos),
    .illegal  (illegal_c)
  );

  sx_extend #(.XLEN(XLEN)) u_ext (
    .operand  (in_operand),
    .sign_pos (sign_pos),
    .result   (ext_c)
  );

  // next-state logic
  logic            valid_d;
  logic [XLEN-1:0] result_d;
  logic            illegal_d;
  always_comb begin
    valid_d   = in_valid;
    result_d  = out_result;
    illegal_d = out_illegal;
    if (in_valid) begin
      result_d  = ext_c;
      illegal_d = illegal_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_result  <= result_d;
      out_illegal <= illegal_d;
    end
  end

  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
  // R7
  a_r7_reserved_pass: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op == 2'd3) |=> (out_illegal && out_result == $past(in_operand)));
  a_r7_legal_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op != 2'd3) |=> !out_illegal);
  // R1
  a_r1_byte_field: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op == 2'd0 && !in_legacy) |=>
      (out_result[FB-1:0] == $past(in_operand[FB-1:0]) &&
       ((&out_result[XLEN-1:FB-1]) || !(|out_result[XLEN-1:FB-1]))));
  // R2
  a_r2_half_field: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op == 2'd1 && !in_legacy) |=>
      (out_result[FH-1:0] == $past(in_operand[FH-1:0]) &&
       ((&out_result[XLEN-1:FH-1]) || !(|out_result[XLEN-1:FH-1]))));
  // R3
  a_r3_word_field: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op == 2'd2 && !in_legacy) |=>
      (out_result[FW-1:0] == $past(in_operand[FW-1:0]) &&
       ((&out_result[XLEN-1:FW-1]) || !(|out_result[XLEN-1:FW-1]))));
  // R10
  a_r10_reset_idle: assert property (@(posedge clk) !rst_ok |-> !out_valid);
endmodule

// File: tb/test_sx_scaled_ext.sv
`timescale 1ns/1ps
module test_sx_scaled_ext;
  localparam int XLEN = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      in_op;
  logic            in_legacy;
  logic [XLEN-1:0] in_operand;
  logic            out_valid;
  logic [XLEN-1:0] out_result;
  logic            out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sx_scaled_ext #(.XLEN(XLEN)) i_sx_scaled_ext (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_legacy(in_legacy), .in_operand(in_operand), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  // reference from the requirements: extend the low w bits; w >= XLEN is a pass-through
  function automatic logic [XLEN-1:0] ref_ext(logic [XLEN-1:0] v, int w);
    logic [XLEN-1:0] r;
    if (w >= XLEN) return v;
    for (int i = 0; i < XLEN; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request, then outputs read at the next falling edge
  task automatic issue(logic [1:0] op, logic leg, logic [XLEN-1:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_legacy = leg; in_operand = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_legacy = 1'b0; in_operand = '0;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", out_valid, 0);
    chk("R10 illegal in reset", out_illegal, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 valid after release", out_valid, 0);
  endtask

  task automatic t_byte;
    issue(2'd0, 1'b0, 16'h1232);
    chk("R1 byte neg", out_result, 16'hFFFE);
    chk("R8 valid", out_valid, 1);
    chk("R7 legal clear", out_illegal, 0);
    issue(2'd0, 1'b0, 16'hFFFD);
    chk("R1 R4 byte pos", out_result, 16'h0001);
  endtask

  task automatic t_half;
    issue(2'd1, 1'b0, 16'h0008);
    chk("R2 half neg", out_result, 16'hFFF8);
    issue(2'd1, 1'b0, 16'hABC7);
    chk("R2 R4 half pos", out_result, 16'h0007);
  endtask

  task automatic t_word;
    issue(2'd2, 1'b0, 16'h7F80);
    chk("R3 word neg", out_result, 16'hFF80);
    issue(2'd2, 1'b0, 16'h807F);
    chk("R3 R4 word pos", out_result, 16'h007F);
  endtask

  task automatic t_sweep;
    logic [XLEN-1:0] pats [4] = '{16'h5555, 16'hAAAA, 16'h0F0F, 16'hC3C3};
    for (int p = 0; p < 4; p++) begin
      issue(2'd0, 1'b0, pats[p]); chk("R1 sweep", out_result, ref_ext(pats[p], 2));
      issue(2'd1, 1'b0, pats[p]); chk("R2 sweep", out_result, ref_ext(pats[p], 4));
      issue(2'd2, 1'b0, pats[p]); chk("R3 sweep", out_result, ref_ext(pats[p], 8));
    end
  endtask

  task automatic t_legacy;
    issue(2'd0, 1'b1, 16'h00F0);
    chk("R5 legacy byte", out_result, 16'hFFF0);
    issue(2'd0, 1'b1, 16'hFF70);
    chk("R5 legacy byte pos", out_result, 16'h0070);
    issue(2'd1, 1'b1, 16'h8234);
    chk("R6 legacy half no-op", out_result, 16'h8234);
    issue(2'd2, 1'b1, 16'h8123);
    chk("R6 legacy word trunc", out_result, 16'h8123);
    chk("R7 legacy legal", out_illegal, 0);
  endtask

  task automatic t_reserved;
    issue(2'd3, 1'b0, 16'h8001);
    chk("R7 reserved result", out_result, 16'h8001);
    chk("R7 reserved flag", out_illegal, 1);
    issue(2'd3, 1'b1, 16'h0180);
    chk("R7 reserved legacy", out_result, 16'h0180);
    issue(2'd1, 1'b0, 16'h0003);
    chk("R7 flag clears", out_illegal, 0);
  endtask

  task automatic t_hold;
    issue(2'd3, 1'b0, 16'h4321);
    @(negedge clk);
    in_op = 2'd0; in_legacy = 1'b1; in_operand = 16'h00FF;
    @(negedge clk);
    chk("R9 hold result", out_result, 16'h4321);
    chk("R9 hold illegal", out_illegal, 1);
    chk("R8 no valid when idle", out_valid, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd2; in_legacy = 1'b0; in_operand = 16'h0090;
    @(negedge clk);
    chk("R8 b2b first", out_result, 16'hFF90);
    chk("R8 b2b valid1", out_valid, 1);
    in_op = 2'd0; in_operand = 16'h0001;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second", out_result, 16'h0001);
    chk("R8 b2b valid2", out_valid, 1);
    @(negedge clk);
    chk("R8 b2b drop", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_byte();
    t_half();
    t_word();
    t_sweep();
    t_legacy();
    t_reserved();
    t_hold();
    t_back_to_back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule